// File: doc/BRIEF.md
# Clock Output Selector with Divider

This block picks one of seven free-running internal clocks and drives it, optionally slowed down, onto a single clock output pin. A 4-bit select code chooses the source. The codes are sparse: some of them deliver a PLL clock at half its rate, and several deliver nothing. A 6-bit divider setting then divides the chosen clock by any ratio from 1 to 64. Odd ratios keep the high and low phases equal by using both edges of the source.

The select and divider inputs are static configuration that software may rewrite at any time. When either one changes, the block gates the output low at once and resets its divide counter on the first rising edge of the new source. It then keeps the output low for a further full source cycle, so no shortened pulse leaves the pin. A code that names no source forces the output low without any clock being needed. It also clears the divider state, so when the code later returns to a valid value the output restarts cleanly.

Top module: `clkout_mux`

## Requirements
- R1: Select codes 0000 through 0011 give no clock. The output stays low.
- R2: Select codes 1100 through 1111 are reserved. They also keep the output low.
- R3: Undivided sources, with divider 0: 0100 gives the system clock, 0101 the RC oscillator, 0110 the crystal, 1000 the second PLL, 1010 the external clock and 1011 the third PLL.
- R4: Code 0111 gives the main PLL at half rate, and code 1001 gives the third PLL at half rate.
- R5: A divider value N produces an output period of (N+1) times the selected clock period. N = 0 passes the clock straight through.
- R6: For every source and divider value the high time of the output is half its period. This includes odd ratios.
- R7: After any change of select code or divider value, including a return from a no-clock code, the next rising output edge comes no sooner than one period of the newly selected clock after the change.
- R8: While rst_n is low the output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 4 | Source select code |
| div | input | 6 | Divider value N, ratio N+1 |
| clk_sys | input | 1 | System clock |
| clk_rc | input | 1 | Internal RC oscillator |
| clk_xtal | input | 1 | Crystal oscillator clock |
| clk_pll | input | 1 | Main PLL output |
| clk_pll1 | input | 1 | Second PLL output |
| clk_pll2 | input | 1 | Third PLL output |
| clk_ext | input | 1 | External clock input |
| clk_out | output | 1 | Gated, divided output clock |

## Verification
A settings change takes effect on the first rising edge of the new source. The divided output then rises one source cycle later. In pass-through mode it rises one further cycle later, because the enable is moved on the falling edge. The bench therefore waits several source periods after each change before it times two full output periods by their edges. For the restart rule it timestamps the change itself and the first output rise after it. No-clock codes take effect combinationally, so they are sampled straight away over a long window.

// File: rtl/clkout_mux.sv
`timescale 1ns/1ps
module clkout_mux #(
  parameter int SEL_W = 4,
  parameter int DIV_W = 6
) (
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  input  logic             clk_sys,
  input  logic             clk_rc,
  input  logic             clk_xtal,
  input  logic             clk_pll,
  input  logic             clk_pll1,
  input  logic             clk_pll2,
  input  logic             clk_ext,
  output logic             clk_out
);
  localparam int CFG_W = SEL_W + DIV_W;

  logic pll_half, pll2_half;

  always_ff @(posedge clk_pll or negedge rst_n)
    if (!rst_n) pll_half <= 1'b0;
    else        pll_half <= ~pll_half;

  always_ff @(posedge clk_pll2 or negedge rst_n)
    if (!rst_n) pll2_half <= 1'b0;
    else        pll2_half <= ~pll2_half;

  logic src_clk, valid;

  always_comb begin
    src_clk = 1'b0;
    valid   = 1'b1;
    case (sel)
      4'b0100: src_clk = clk_sys;
      4'b0101: src_clk = clk_rc;
      4'b0110: src_clk = clk_xtal;
      4'b0111: src_clk = pll_half;
      4'b1000: src_clk = clk_pll1;
      4'b1001: src_clk = pll2_half;
      4'b1010: src_clk = clk_ext;
      4'b1011: src_clk = clk_pll2;
      default: valid   = 1'b0;
    endcase
  end

  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic [DIV_W-1:0] div_q, cnt, cnt_nx, half;
  logic [DIV_W:0]   ratio;
  logic             arst_n, active, q_pos, q_neg, en_n, odd, same;

  assign cfg_now = {sel, div};
  assign arst_n  = rst_n & valid;
  assign div_q   = cfg_q[DIV_W-1:0];
  assign ratio   = {1'b0, div_q} + 1'b1;
  assign half    = ratio[DIV_W:1];
  assign odd     = ratio[0];
  assign cnt_nx  = (cnt == div_q) ? '0 : cnt + 1'b1;
  assign same    = (cfg_now == cfg_q);

  always_ff @(posedge src_clk or negedge arst_n)
    if (!arst_n) begin
      cfg_q  <= '0;
      active <= 1'b0;
      cnt    <= '0;
      q_pos  <= 1'b0;
    end else if (!same) begin
      cfg_q  <= cfg_now;
      active <= 1'b0;
      cnt    <= '0;
      q_pos  <= 1'b0;
    end else if (!active) begin
      active <= 1'b1;
      cnt    <= '0;
      q_pos  <= (half != '0);
    end else begin
      cnt    <= cnt_nx;
      q_pos  <= (cnt_nx < half);
    end

  always_ff @(negedge src_clk or negedge arst_n)
    if (!arst_n) begin
      q_neg <= 1'b0;
      en_n  <= 1'b0;
    end else begin
      q_neg <= q_pos;
      en_n  <= active & (div_q == '0);
    end

  assign clk_out = valid & same & active &
                   ((div_q == '0) ? (src_clk & en_n) : (q_pos | (odd & q_neg)));

endmodule

// File: rtl/clkout_mux_chk.sv
`timescale 1ns/1ps
module clkout_mux_chk #(
  parameter int SEL_W = 4,
  parameter int DIV_W = 6
) (
  input logic                   rst_n,
  input logic                   clk_sys,
  input logic                   clk_pll,
  input logic                   clk_pll2,
  input logic                   src_clk,
  input logic [SEL_W-1:0]       sel,
  input logic [SEL_W+DIV_W-1:0] cfg_now,
  input logic [SEL_W+DIV_W-1:0] cfg_q,
  input logic [DIV_W-1:0]       cnt,
  input logic                   active,
  input logic                   pll_half,
  input logic                   pll2_half,
  input logic                   clk_out
);
  always @(posedge clk_sys)
    if (!rst_n) assert_reset_low_R8: assert (!clk_out);

  assert_noclk_low_R1: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (sel[SEL_W-1:SEL_W-2] == 2'b00) |-> !clk_out);

  assert_reserved_low_R2: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (sel[SEL_W-1:SEL_W-2] == 2'b11) |-> !clk_out);

  assert_pll_half_R4: assert property (@(posedge clk_pll) disable iff (!rst_n)
    rst_n |=> (pll_half != $past(pll_half)));

  assert_pll2_half_R4: assert property (@(posedge clk_pll2) disable iff (!rst_n)
    rst_n |=> (pll2_half != $past(pll2_half)));

  assert_cnt_bound_R5: assert property (@(posedge src_clk) disable iff (!rst_n)
    active |-> (cnt <= cfg_q[DIV_W-1:0]));

  assert_restart_hold_R7: assert property (@(posedge src_clk) disable iff (!rst_n)
    (cfg_now != cfg_q) |=> !active);
endmodule

bind clkout_mux clkout_mux_chk #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_chk (
  .rst_n(rst_n), .clk_sys(clk_sys), .clk_pll(clk_pll), .clk_pll2(clk_pll2),
  .src_clk(src_clk), .sel(sel), .cfg_now(cfg_now), .cfg_q(cfg_q), .cnt(cnt),
  .active(active), .pll_half(pll_half), .pll2_half(pll2_half), .clk_out(clk_out)
);

// File: tb/clkout_mux_bench.sv
`timescale 1ns/1ps
module clkout_mux_bench;
  logic clk = 0, rst_n = 0;
  logic [3:0] sel = 4'b0100;
  logic [5:0] div = 6'd0;
  logic c_sys = 0, c_rc = 0, c_xtal = 0, c_pll = 0, c_pll1 = 0, c_pll2 = 0, c_ext = 0;
  logic clk_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk    = ~clk;
  always #5  c_sys  = ~c_sys;
  always #7  c_rc   = ~c_rc;
  always #11 c_xtal = ~c_xtal;
  always #3  c_pll  = ~c_pll;
  always #13 c_pll1 = ~c_pll1;
  always #4  c_pll2 = ~c_pll2;
  always #17 c_ext  = ~c_ext;

  clkout_mux u_clkout_mux (
    .rst_n(rst_n), .sel(sel), .div(div), .clk_sys(c_sys), .clk_rc(c_rc),
    .clk_xtal(c_xtal), .clk_pll(c_pll), .clk_pll1(c_pll1), .clk_pll2(c_pll2),
    .clk_ext(c_ext), .clk_out(clk_out)
  );

  // {sel, div, expected output period in ns}
  localparam logic [21:0] VEC [15] = '{
    {4'b0100, 6'd0, 12'd10},  {4'b0101, 6'd0, 12'd14},  {4'b0110, 6'd0, 12'd22},
    {4'b0111, 6'd0, 12'd12},  {4'b1000, 6'd0, 12'd26},  {4'b1001, 6'd0, 12'd16},
    {4'b1010, 6'd0, 12'd34},  {4'b1011, 6'd0, 12'd8},   {4'b0100, 6'd1, 12'd20},
    {4'b0100, 6'd2, 12'd30},  {4'b0111, 6'd4, 12'd60},  {4'b1011, 6'd63, 12'd512},
    {4'b1010, 6'd5, 12'd204}, {4'b0110, 6'd3, 12'd88},  {4'b1001, 6'd6, 12'd112}
  };

  task automatic check(input bit ok, input string req, input real act, input real exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] s, input logic [5:0] d);
    @(posedge clk);
    #3.3;
    sel = s;
    div = d;
  endtask

  task automatic measure(output real per, output real hi);
    real t0, t1, t2;
    @(posedge clk_out); t0 = $realtime;
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  task automatic quiet(input string req);
    int highs = 0;
    for (int i = 0; i < 150; i++) begin
      #3.7;
      if (clk_out) highs++;
    end
    check(highs == 0, req, highs, 0);
  endtask

  task automatic restart(input logic [3:0] s0, input logic [5:0] d0,
                         input logic [3:0] s1, input logic [5:0] d1, input real tnew);
    real tc, tr;
    apply(s0, d0);
    if (s0[3:2] == 2'b01 || s0[3:2] == 2'b10) begin
      #400;
      @(posedge clk_out);
    end else #200;
    #1.3;
    tc  = $realtime;
    sel = s1;
    div = d1;
    @(posedge clk_out);
    tr = $realtime;
    check(tr - tc >= tnew - 0.01, "R7", tr - tc, tnew);
  endtask

  initial begin
    real per, hi, exp;
    repeat (3) @(posedge clk);
    for (int i = 0; i < 20; i++) begin
      #3.7;
      check(clk_out == 1'b0, "R8", clk_out, 0);
    end
    rst_n = 1;

    foreach (VEC[i]) begin
      apply(VEC[i][21:18], VEC[i][17:12]);
      exp = VEC[i][11:0];
      #(exp * 3 + 150);
      measure(per, hi);
      // R3/R4 source choice and R5 ratio
      check(per > exp - 0.05 && per < exp + 0.05, "R3/R4/R5 period", per, exp);
      // R6 half duty
      check(hi > per / 2 - 0.05 && hi < per / 2 + 0.05, "R6 high time", hi, per / 2);
    end

    apply(4'b0000, 6'd0); quiet("R1 code 0000");
    apply(4'b0011, 6'd5); quiet("R1 code 0011");
    apply(4'b1100, 6'd0); quiet("R2 code 1100");
    apply(4'b1111, 6'd2); quiet("R2 code 1111");

    restart(4'b0100, 6'd1, 4'b0100, 6'd3, 10.0);
    restart(4'b0110, 6'd0, 4'b1010, 6'd2, 34.0);
    restart(4'b0000, 6'd0, 4'b0101, 6'd0, 14.0);
    restart(4'b1011, 6'd2, 4'b0111, 6'd1, 12.0);
    #100;
    measure(per, hi);
    check(per > 23.95 && per < 24.05, "R7 period after restart", per, 24.0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule